// File: doc/BRIEF.md
# Shadow Region Attribute Decoder

This block routes processor memory cycles in the upper legacy window, C0000h to FFFFFh, to one of two places: main memory or the downstream hub. The window is cut into thirteen segments of uneven size. Each segment has a 2-bit attribute with separate read and write enables. A read and a write to the same address can therefore be sent to different places. Firmware uses this to shadow its ROM image into RAM. It first reads from the hub while writing to memory, then switches reads to memory as well.

Each request is a single-cycle strobe that carries an address and a read/write flag. The route comes out one cycle later as exactly one of three flags: memory, hub or not claimed. Software programs the attributes through an indexed write port. Turning off an enable never moves the segment to some other address: the cycle simply goes to the hub. Addresses outside the window, including any address with a bit set above bit 19, are reported as not claimed.

Top module: `shadow_route_dec`

## Requirements
- R1: After reset every attribute is 00, so every read and every write to any segment in the window, including F0000h–FFFFFh, is routed to the hub.
- R2: C0000h–DFFFFh is eight 16 KB segments with indices 0 to 7; the index is (address − C0000h) / 4000h.
- R3: E0000h–EFFFFh is four 16 KB segments with indices 8 to 11; the index is 8 + (address − E0000h) / 4000h.
- R4: F0000h–FFFFFh is one 64 KB segment with index 12.
- R5: Attribute encoding: bit 0 is the read enable and bit 1 is the write enable. So 00 is disabled, 01 is read-only, 10 is write-only and 11 is read/write. A read goes to memory only when bit 0 of its segment is set.
- R6: A write (wr_i=1) goes to memory only when bit 1 of its segment is set.
- R7: A read or write whose enable is clear goes to the hub, never to memory and never to another address.
- R8: A request whose address lies outside C0000h–FFFFFh, including any address with a bit above bit 19 set, raises unclaimed_o and raises neither to_mem_o nor to_hub_o.
- R9: A configuration write with cfg_idx_i of 13 or more changes no attribute.
- R10: The route for a request appears on the outputs one cycle after req_i. An attribute write takes effect for requests issued in the cycle after the write. A request issued in the same cycle as the write still sees the old value.
- R11: With no request in the previous cycle, rsp_valid_o, to_mem_o, to_hub_o and unclaimed_o are all low. With a request, exactly one of the three route flags is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Attribute write strobe |
| cfg_idx_i | input | 4 | Segment index to write |
| cfg_attr_i | input | 2 | New attribute (bit 0 read enable, bit 1 write enable) |
| req_i | input | 1 | Request strobe |
| addr_i | input | ADDR_W | Request byte address |
| wr_i | input | 1 | 1 = write, 0 = read |
| rsp_valid_o | output | 1 | A route result is present |
| to_mem_o | output | 1 | Route the cycle to main memory |
| to_hub_o | output | 1 | Route the cycle to the downstream hub |
| unclaimed_o | output | 1 | The address lies outside the window |

## Verification
The bench builds the block with ADDR_W set to 24 rather than the default 20. This exposes address bits above the 1 MB boundary, so an address such as 8C0000h, whose low 20 bits fall inside the window, must still be reported as not claimed. It sweeps the first and last address of all thirteen segments under all four attribute codes, for both reads and writes. It also places a request in the same cycle as an attribute write to confirm where the old and new values take effect.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int EXP_SEGS  = 8;
  localparam int EXT_SEGS  = 4;
  localparam int TOP_SEGS  = 1;
  localparam int NUM_SEGS  = EXP_SEGS + EXT_SEGS + TOP_SEGS;
  localparam int SEG_IDX_W = $clog2(NUM_SEGS);
  localparam int BASE_W    = 20;

  typedef enum logic [1:0] {
    ATTR_OFF = 2'b00,
    ATTR_RD  = 2'b01,
    ATTR_WR  = 2'b10,
    ATTR_RW  = 2'b11
  } attr_e;

  typedef struct packed {
    logic                 hit;
    logic [SEG_IDX_W-1:0] idx;
  } seg_sel_t;
endpackage

// File: rtl/shadow_seg_idx.sv
module shadow_seg_idx
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 hit_o,
  output logic [SEG_IDX_W-1:0] idx_o
);
  logic     upper_ok;
  seg_sel_t sel;

  if (ADDR_W > BASE_W) begin : g_wide
    assign upper_ok = ~|addr_i[ADDR_W-1:BASE_W];
  end else begin : g_base
    assign upper_ok = 1'b1;
  end

  always_comb begin
    sel.hit = upper_ok && (addr_i[19:18] == 2'b11);
    if (!addr_i[17])
      sel.idx = SEG_IDX_W'(addr_i[16:14]);                       // C0000-DFFFF
    else if (!addr_i[16])
      sel.idx = SEG_IDX_W'(EXP_SEGS) + SEG_IDX_W'(addr_i[15:14]); // E0000-EFFFF
    else
      sel.idx = SEG_IDX_W'(EXP_SEGS + EXT_SEGS);                  // F0000-FFFFF
  end

  assign hit_o = sel.hit;
  assign idx_o = sel.idx;
endmodule

// File: rtl/shadow_attr_regs.sv
module shadow_attr_regs
  import shadow_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [SEG_IDX_W-1:0]  idx_i,
  input  logic [1:0]            attr_i,
  output logic [2*NUM_SEGS-1:0] attr_flat_o
);
  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    attr_e attr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        attr_q <= ATTR_OFF;
      else if (we_i && idx_i == SEG_IDX_W'(g))
        attr_q <= attr_e'(attr_i);
    end
    assign attr_flat_o[2*g +: 2] = attr_q;
  end
endmodule

// File: rtl/shadow_route_dec.sv
module shadow_route_dec
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [SEG_IDX_W-1:0] cfg_idx_i,
  input  logic [1:0]           cfg_attr_i,
  input  logic                 req_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  output logic                 rsp_valid_o,
  output logic                 to_mem_o,
  output logic                 to_hub_o,
  output logic                 unclaimed_o
);
  logic [2*NUM_SEGS-1:0] attr_flat;
  logic                  seg_hit;
  logic [SEG_IDX_W-1:0]  seg_idx;
  logic [1:0]            seg_attr;
  logic                  mem_en;

  shadow_attr_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .idx_i       (cfg_idx_i),
    .attr_i      (cfg_attr_i),
    .attr_flat_o (attr_flat)
  );

  shadow_seg_idx #(.ADDR_W(ADDR_W)) u_idx (
    .addr_i (addr_i),
    .hit_o  (seg_hit),
    .idx_o  (seg_idx)
  );

  always_comb begin
    seg_attr = ATTR_OFF;
    if (seg_idx < SEG_IDX_W'(NUM_SEGS))
      seg_attr = attr_flat[{seg_idx, 1'b0} +: 2];
    mem_en = wr_i ? seg_attr[1] : seg_attr[0];
  end

  // Route registered: attr written at edge N applies to requests sampled at N+1.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      to_mem_o    <= 1'b0;
      to_hub_o    <= 1'b0;
      unclaimed_o <= 1'b0;
    end else begin
      rsp_valid_o <= req_i;
      to_mem_o    <= req_i &  seg_hit &  mem_en;
      to_hub_o    <= req_i &  seg_hit & ~mem_en;
      unclaimed_o <= req_i & ~seg_hit;
    end
  end
endmodule

// File: rtl/shadow_route_chk.sv
module shadow_route_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rsp_valid_o,
  input logic              to_mem_o,
  input logic              to_hub_o,
  input logic              unclaimed_o
);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(32'h000C_0000);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(32'h000F_FFFF);

  logic in_win;
  assign in_win = (addr_i >= WIN_LO) && (addr_i <= WIN_HI);

  // R10
  resp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  // R11
  one_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({to_mem_o, to_hub_o, unclaimed_o}) == 1);

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(to_mem_o || to_hub_o || unclaimed_o));

  // R8
  outside_unclaimed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !in_win) |=> (unclaimed_o && !to_mem_o && !to_hub_o));

  // R7
  inside_claimed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && in_win) |=> (to_mem_o || to_hub_o));
endmodule

bind shadow_route_dec shadow_route_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .addr_i      (addr_i),
  .rsp_valid_o (rsp_valid_o),
  .to_mem_o    (to_mem_o),
  .to_hub_o    (to_hub_o),
  .unclaimed_o (unclaimed_o)
);

// File: tb/tb_shadow_route_dec.sv
`timescale 1ns/1ps
module tb_shadow_route_dec;
  localparam int AW = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [3:0]    cfg_idx_i = '0;
  logic [1:0]    cfg_attr_i = '0;
  logic          req_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          wr_i = 1'b0;
  logic          rsp_valid_o, to_mem_o, to_hub_o, unclaimed_o;

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  string cur_tag = "R11";
  string exp_tag = "R1";
  int    attr_m[13];
  bit    e_vld, e_mem, e_hub, e_unc;

  always #2.5 clk_i = ~clk_i;

  shadow_route_dec #(.ADDR_W(AW)) dut (.*);

  function automatic int seg_of(longint a);
    if (a >= 'hC0000 && a < 'hE0000) return int'((a - 'hC0000) / 'h4000);
    if (a >= 'hE0000 && a < 'hF0000) return 8 + int'((a - 'hE0000) / 'h4000);
    if (a >= 'hF0000 && a <= 'hFFFFF) return 12;
    return -1;
  endfunction

  // Reference model: route computed from the attributes before this edge's write.
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (attr_m[i]) attr_m[i] = 0;
      {e_vld, e_mem, e_hub, e_unc} = '0;
      exp_tag = "R1";
    end else begin
      int s;
      bit en;
      s = seg_of(longint'(addr_i));
      e_vld = req_i;
      e_mem = 0; e_hub = 0; e_unc = 0;
      if (req_i) begin
        if (s < 0) e_unc = 1;
        else begin
          en = wr_i ? attr_m[s][1] : attr_m[s][0];
          if (en) e_mem = 1; else e_hub = 1;
        end
      end
      exp_tag = cur_tag;
      if (cfg_we_i && cfg_idx_i < 13) attr_m[cfg_idx_i] = cfg_attr_i;
    end
  end

  always @(negedge clk_i) begin
    if (!finished) begin
      total++;
      if ({rsp_valid_o, to_mem_o, to_hub_o, unclaimed_o} !== {e_vld, e_mem, e_hub, e_unc}) begin
        bad++;
        $display("FAIL %s: got vld/mem/hub/unc=%b%b%b%b expected %b%b%b%b",
                 exp_tag, rsp_valid_o, to_mem_o, to_hub_o, unclaimed_o,
                 e_vld, e_mem, e_hub, e_unc);
      end
    end
  end

  task automatic step(bit we, int idx, int at, bit rq, longint a, bit w, string tag);
    cfg_we_i = we; cfg_idx_i = 4'(idx); cfg_attr_i = 2'(at);
    req_i = rq; addr_i = AW'(a); wr_i = w; cur_tag = tag;
    @(negedge clk_i);
  endtask

  task automatic access(longint a, bit w, string tag);
    step(0, 0, 0, 1, a, w, tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle("R11"); idle("R11");
    // R1: everything goes to the hub after reset
    access('hF0000, 0, "R1"); access('hFFFFF, 1, "R1");
    access('hC0000, 0, "R1"); access('hE4000, 1, "R1");
    // R9: out-of-range indices change nothing
    step(1, 13, 3, 0, 0, 0, "R9");
    step(1, 14, 3, 0, 0, 0, "R9");
    step(1, 15, 3, 0, 0, 0, "R9");
    for (int s = 0; s < 13; s++) begin
      longint b = (s < 8) ? 'hC0000 + s * 'h4000 : (s < 12) ? 'hE0000 + (s - 8) * 'h4000 : 'hF0000;
      access(b, 0, "R9"); access(b, 1, "R9");
    end
    // R5 R6 R7 with R2 R3 R4 segment layout; several attribute patterns
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 13; s++) step(1, s, (s + p) % 4, 0, 0, 0, "R5");
      for (int s = 0; s < 13; s++) begin
        longint b, sz;
        string t;
        if (s < 8) begin b = 'hC0000 + s * 'h4000; sz = 'h4000; t = "R2"; end
        else if (s < 12) begin b = 'hE0000 + (s - 8) * 'h4000; sz = 'h4000; t = "R3"; end
        else begin b = 'hF0000; sz = 'h10000; t = "R4"; end
        access(b, 0, t); access(b, 1, "R6");
        access(b + sz - 1, 0, "R5"); access(b + sz - 1, 1, "R7");
      end
    end
    // R8: outside the window
    access('h00000, 0, "R8"); access('hBFFFF, 1, "R8");
    access('h100000, 0, "R8"); access('h8C0000, 1, "R8");
    access('hFFFFFF, 0, "R8");
    idle("R11");
    // R10: write timing against the top segment
    step(1, 12, 0, 0, 0, 0, "R10");
    step(1, 12, 3, 1, 'hF8000, 0, "R10");
    access('hF8000, 0, "R10"); access('hF8000, 1, "R10");
    step(1, 12, 1, 1, 'hF0000, 1, "R10");
    access('hF0000, 1, "R10"); access('hF0000, 0, "R10");
    step(1, 5, 2, 1, 'hD4000, 1, "R10");
    access('hD4000, 1, "R10"); access('hD7FFF, 0, "R7");
    idle("R11"); idle("R11");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog: got hung expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule